// File: doc/BRIEF.md
# Long Branch and Call Frame Unit

This unit resolves an IP-relative branch with a long displacement. A 60-bit immediate is scaled by 16 and added to the current 64-bit instruction pointer to form the target. The branch comes in two forms, a plain conditional branch and a call. Both are taken exactly when the qualifying predicate is 1. A taken call also writes a return link and saves the caller's frame marker, epilogue count and privilege level into a saved-frame register. It then shrinks the current register frame to its output area and pulses a request so that an external register-stack engine preserves the locals.

Each request is presented with a one-cycle valid strobe. Its results appear, registered, on the following cycle. The checks for unimplemented addresses are done elsewhere and arrive as flags. The unit combines them with the translation mode and the early-fault capability to decide on the address trap. A missing feature raises an illegal-operation fault. A missing stop after the instruction is flagged as an error. In both cases the unit leaves all architectural state untouched.

Top module: `lbr_call_unit`

## Requirements
- R1: One cycle after `in_vld` is high, `out_vld` is high for one cycle. When `ip_redirect` is 1, `next_ip` equals `cur_ip + (disp << 4)`, taken modulo 2^64.
- R2: When the fault and error conditions are clear (`feat_ok`=1, `stop_follows`=1), the branch is taken exactly when `pred`=1, for both `is_call`=0 (conditional) and `is_call`=1 (call). A taken branch sets `ip_redirect`=1. When the branch is not taken, `ip_redirect`=0 and `next_ip` equals `cur_ip + 16`.
- R3: A taken call sets `link_we`=1, drives `link_sel` with `link_idx`, and drives `link_data` with `cur_ip + 16`.
- R4: A taken call sets `pfs_we`=1 and drives three fields. `pfs_frame` carries the whole incoming frame packed as {rbpr[37:32], rbfr[31:25], rbgr[24:18], rot[17:14], locals[13:7], size[6:0]}. `pfs_epi` carries `epi_cnt` and `pfs_pl` carries `cur_pl`.
- R5: A taken call sets `frame_we`=1 and `preserve_req`=1. The new frame size `nf_size` is `cf_size - cf_locals` (7-bit). The new locals, rotating size and the three rotating bases are all zero.
- R6: A branch that is not taken, and any conditional branch, leaves `link_we`, `pfs_we`, `frame_we` and `preserve_req` at 0. In that case the `nf_*` outputs equal the incoming frame fields.
- R7: With `feat_ok`=0, `ill_op` is 1. No write, redirect, trap or preserve request is produced.
- R8: With `feat_ok`=1 and `stop_follows`=0, `undef_err` is 1 and no write, redirect, trap or preserve request is produced. When `feat_ok`=0, `undef_err` stays 0 because the illegal-operation fault takes priority.
- R9: A taken branch raises `ua_trap` when `early_ua_ok`=0 and the target is flagged as unimplemented. The flag used is `va_unimpl` when `trans_on`=1 and `pa_unimpl` when `trans_on`=0.
- R10: A taken branch raises `tb_trap` when `tb_en`=1. This trap can fire in the same cycle as `ua_trap`.
- R11: While reset is held and after it is released, with no request pending, `out_vld` and every write strobe, trap and pulse output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Request strobe |
| cur_ip | input | 64 | Current instruction pointer |
| disp | input | 60 | Displacement in 16-byte units |
| is_call | input | 1 | 1 = call form, 0 = conditional form |
| pred | input | 1 | Qualifying predicate value |
| link_idx | input | 3 | Link register index for a call |
| cf_size | input | 7 | Current frame size |
| cf_locals | input | 7 | Current size of locals |
| cf_rot | input | 4 | Current size of rotating region |
| cf_rbgr | input | 7 | General rotating base |
| cf_rbfr | input | 7 | Floating rotating base |
| cf_rbpr | input | 6 | Predicate rotating base |
| epi_cnt | input | 6 | Epilogue count |
| cur_pl | input | 2 | Current privilege level |
| trans_on | input | 1 | Instruction translation enabled |
| tb_en | input | 1 | Taken-branch trap enable |
| feat_ok | input | 1 | Long branch implemented |
| early_ua_ok | input | 1 | Unimplemented-address faults are raised early elsewhere |
| va_unimpl | input | 1 | Target is an unimplemented virtual address |
| pa_unimpl | input | 1 | Target is an unimplemented physical address |
| stop_follows | input | 1 | Instruction is followed by a stop |
| out_vld | output | 1 | Result valid |
| ip_redirect | output | 1 | Branch taken, load `next_ip` |
| next_ip | output | 64 | Target or fall-through address |
| link_we | output | 1 | Link register write |
| link_sel | output | 3 | Link register index |
| link_data | output | 64 | Return address |
| pfs_we | output | 1 | Saved-frame register write |
| pfs_frame | output | 38 | Saved frame marker |
| pfs_epi | output | 6 | Saved epilogue count |
| pfs_pl | output | 2 | Saved privilege level |
| frame_we | output | 1 | Frame marker update |
| nf_size | output | 7 | New frame size |
| nf_locals | output | 7 | New size of locals |
| nf_rot | output | 4 | New rotating size |
| nf_rbgr | output | 7 | New general rotating base |
| nf_rbfr | output | 7 | New floating rotating base |
| nf_rbpr | output | 6 | New predicate rotating base |
| ill_op | output | 1 | Illegal-operation fault |
| undef_err | output | 1 | Missing stop error |
| ua_trap | output | 1 | Unimplemented-address trap |
| tb_trap | output | 1 | Taken-branch trap |
| preserve_req | output | 1 | Request to preserve the locals |

## Verification
Two functions can fire in the same result cycle: the unimplemented-address trap and the taken-branch trap. The bench provokes this with a taken call that has `tb_en`=1 and `early_ua_ok`=0, and whose unimplemented flag for the active translation mode is set. It expects both trap pulses together with the redirect, the link write and the frame update. Neighbouring cases separate the two traps: the flag for the inactive mode is set, early faulting is enabled, or trapping is disabled. Each trap is then expected alone and judged against a model of the requirements.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
   localparam int SOF_W = 7;
   localparam int SOL_W = 7;
   localparam int SOR_W = 4;
   localparam int RBG_W = 7;
   localparam int RBF_W = 7;
   localparam int RBP_W = 6;

   typedef struct packed {
      logic [RBP_W-1:0] rb_pr;
      logic [RBF_W-1:0] rb_fr;
      logic [RBG_W-1:0] rb_gr;
      logic [SOR_W-1:0] rot;
      logic [SOL_W-1:0] locals;
      logic [SOF_W-1:0] size;
   } frame_t;

   localparam int FRAME_W = $bits(frame_t);
endpackage

// File: rtl/lbr_target.sv
module lbr_target #(
   parameter int IP_W   = 64,
   parameter int DISP_W = 60,
   parameter int SHIFT  = 4,
   parameter int STEP   = 16
) (
   input  logic [IP_W-1:0]   ip,
   input  logic [DISP_W-1:0] disp,
   output logic [IP_W-1:0]   target,
   output logic [IP_W-1:0]   fallthru
);
   localparam int SPAN = DISP_W + SHIFT;

   logic [IP_W-1:0] offset;

   generate
      if (SPAN > IP_W) begin : g_bad_span
         $error("lbr_target: scaled displacement wider than IP");
      end
      if (SPAN == IP_W) begin : g_full
         // displacement fills the IP exactly: addition wraps naturally
         assign offset = {disp, {SHIFT{1'b0}}};
      end else begin : g_sext
         assign offset = {{(IP_W-SPAN){disp[DISP_W-1]}}, disp, {SHIFT{1'b0}}};
      end
   endgenerate

   assign target   = ip + offset;
   assign fallthru = ip + IP_W'(STEP);
endmodule

// File: rtl/lbr_frame.sv
module lbr_frame (
   input  lbr_pkg::frame_t cur,
   output lbr_pkg::frame_t shrunk
);
   always_comb begin
      shrunk        = '0;
      shrunk.size   = cur.size - cur.locals;
   end
endmodule

// File: rtl/lbr_resolve.sv
module lbr_resolve (
   input  logic vld,
   input  logic feat_ok,
   input  logic stop_follows,
   input  logic pred,
   input  logic is_call,
   input  logic trans_on,
   input  logic early_ua_ok,
   input  logic va_unimpl,
   input  logic pa_unimpl,
   input  logic tb_en,
   output logic taken,
   output logic call_taken,
   output logic ill,
   output logic undef,
   output logic ua,
   output logic tbt
);
   logic proceed;
   logic bad_addr;

   always_comb begin
      ill        = vld && !feat_ok;
      undef      = vld && feat_ok && !stop_follows;
      proceed    = vld && feat_ok && stop_follows;
      taken      = proceed && pred;
      call_taken = taken && is_call;
      bad_addr   = trans_on ? va_unimpl : pa_unimpl;
      ua         = taken && !early_ua_ok && bad_addr;
      tbt        = taken && tb_en;
   end

   always_comb begin
      // R8
      undef_prio_chk: assert (!(ill && undef));
   end
endmodule

// File: rtl/lbr_call_unit.sv
module lbr_call_unit #(
   parameter int IP_W   = 64,
   parameter int DISP_W = 60,
   parameter int SHIFT  = 4,
   parameter int LINK_W = 3,
   parameter int EPI_W  = 6,
   parameter int PL_W   = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_vld,
   input  logic [IP_W-1:0]           cur_ip,
   input  logic [DISP_W-1:0]         disp,
   input  logic                      is_call,
   input  logic                      pred,
   input  logic [LINK_W-1:0]         link_idx,
   input  logic [lbr_pkg::SOF_W-1:0] cf_size,
   input  logic [lbr_pkg::SOL_W-1:0] cf_locals,
   input  logic [lbr_pkg::SOR_W-1:0] cf_rot,
   input  logic [lbr_pkg::RBG_W-1:0] cf_rbgr,
   input  logic [lbr_pkg::RBF_W-1:0] cf_rbfr,
   input  logic [lbr_pkg::RBP_W-1:0] cf_rbpr,
   input  logic [EPI_W-1:0]          epi_cnt,
   input  logic [PL_W-1:0]           cur_pl,
   input  logic                      trans_on,
   input  logic                      tb_en,
   input  logic                      feat_ok,
   input  logic                      early_ua_ok,
   input  logic                      va_unimpl,
   input  logic                      pa_unimpl,
   input  logic                      stop_follows,
   output logic                      out_vld,
   output logic                      ip_redirect,
   output logic [IP_W-1:0]           next_ip,
   output logic                      link_we,
   output logic [LINK_W-1:0]         link_sel,
   output logic [IP_W-1:0]           link_data,
   output logic                      pfs_we,
   output logic [lbr_pkg::FRAME_W-1:0] pfs_frame,
   output logic [EPI_W-1:0]          pfs_epi,
   output logic [PL_W-1:0]           pfs_pl,
   output logic                      frame_we,
   output logic [lbr_pkg::SOF_W-1:0] nf_size,
   output logic [lbr_pkg::SOL_W-1:0] nf_locals,
   output logic [lbr_pkg::SOR_W-1:0] nf_rot,
   output logic [lbr_pkg::RBG_W-1:0] nf_rbgr,
   output logic [lbr_pkg::RBF_W-1:0] nf_rbfr,
   output logic [lbr_pkg::RBP_W-1:0] nf_rbpr,
   output logic                      ill_op,
   output logic                      undef_err,
   output logic                      ua_trap,
   output logic                      tb_trap,
   output logic                      preserve_req
);
   import lbr_pkg::*;

   localparam int BUNDLE_BYTES = 16;

   generate
      if (LINK_W < 1 || EPI_W < 1 || PL_W < 1) begin : g_bad_w
         $error("lbr_call_unit: field widths must be positive");
      end
      if (SOL_W != SOF_W) begin : g_bad_frame
         $error("lbr_call_unit: locals and frame size widths differ");
      end
      if ((1 << SHIFT) != BUNDLE_BYTES) begin : g_bad_shift
         $error("lbr_call_unit: shift must scale to one bundle");
      end
   endgenerate

   frame_t          cur_fr;
   frame_t          new_fr;
   frame_t          nf_q;
   logic [IP_W-1:0] tgt;
   logic [IP_W-1:0] ft;
   logic            taken, call_taken, ill, undef, ua, tbt;

   always_comb begin
      cur_fr.size   = cf_size;
      cur_fr.locals = cf_locals;
      cur_fr.rot    = cf_rot;
      cur_fr.rb_gr  = cf_rbgr;
      cur_fr.rb_fr  = cf_rbfr;
      cur_fr.rb_pr  = cf_rbpr;
   end

   lbr_target #(
      .IP_W(IP_W), .DISP_W(DISP_W), .SHIFT(SHIFT), .STEP(BUNDLE_BYTES)
   ) u_target (
      .ip(cur_ip), .disp(disp), .target(tgt), .fallthru(ft)
   );

   lbr_frame u_frame (.cur(cur_fr), .shrunk(new_fr));

   lbr_resolve u_resolve (
      .vld(in_vld), .feat_ok(feat_ok), .stop_follows(stop_follows),
      .pred(pred), .is_call(is_call), .trans_on(trans_on),
      .early_ua_ok(early_ua_ok), .va_unimpl(va_unimpl),
      .pa_unimpl(pa_unimpl), .tb_en(tb_en),
      .taken(taken), .call_taken(call_taken), .ill(ill),
      .undef(undef), .ua(ua), .tbt(tbt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld      <= 1'b0;
         ip_redirect  <= 1'b0;
         next_ip      <= '0;
         link_we      <= 1'b0;
         link_sel     <= '0;
         link_data    <= '0;
         pfs_we       <= 1'b0;
         pfs_frame    <= '0;
         pfs_epi      <= '0;
         pfs_pl       <= '0;
         frame_we     <= 1'b0;
         nf_q         <= '0;
         ill_op       <= 1'b0;
         undef_err    <= 1'b0;
         ua_trap      <= 1'b0;
         tb_trap      <= 1'b0;
         preserve_req <= 1'b0;
      end else begin
         out_vld      <= in_vld;
         ip_redirect  <= taken;
         next_ip      <= taken ? tgt : ft;
         link_we      <= call_taken;
         link_sel     <= link_idx;
         link_data    <= ft;
         pfs_we       <= call_taken;
         pfs_frame    <= cur_fr;
         pfs_epi      <= epi_cnt;
         pfs_pl       <= cur_pl;
         frame_we     <= call_taken;
         nf_q         <= call_taken ? new_fr : cur_fr;
         ill_op       <= ill;
         undef_err    <= undef;
         ua_trap      <= ua;
         tb_trap      <= tbt;
         preserve_req <= call_taken;
      end
   end

   assign nf_size   = nf_q.size;
   assign nf_locals = nf_q.locals;
   assign nf_rot    = nf_q.rot;
   assign nf_rbgr   = nf_q.rb_gr;
   assign nf_rbfr   = nf_q.rb_fr;
   assign nf_rbpr   = nf_q.rb_pr;

   // R1
   out_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);

   // R2
   not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && feat_ok && stop_follows && !pred) |=> (!ip_redirect && !frame_we && !link_we));

   // R5
   call_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && feat_ok && stop_follows && pred && is_call)
         |=> (link_we && pfs_we && frame_we && preserve_req && ip_redirect));

   // R7
   ill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ill_op |-> !(link_we || pfs_we || frame_we || ip_redirect || ua_trap || tb_trap || preserve_req));

   // R9
   ua_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ua_trap |-> (ip_redirect && out_vld));

   // R10
   tb_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tb_trap |-> (ip_redirect && out_vld));
endmodule

// File: tb/lbr_call_unit_tb_top.sv
module lbr_call_unit_tb_top;
   typedef struct {
      logic [63:0] ip;
      logic [59:0] d;
      logic        call;
      logic        pred;
      logic [2:0]  li;
      logic [37:0] fr;
      logic [5:0]  epi;
      logic [1:0]  pl;
      logic        tr;
      logic        tb;
      logic        feat;
      logic        early;
      logic        va;
      logic        pa;
      logic        stop;
   } stim_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        in_vld = 0, is_call = 0, pred = 0;
   logic [63:0] cur_ip = '0;
   logic [59:0] disp = '0;
   logic [2:0]  link_idx = '0;
   logic [37:0] frin = '0;
   logic [5:0]  epi_cnt = '0;
   logic [1:0]  cur_pl = '0;
   logic        trans_on = 0, tb_en = 0, feat_ok = 1, early_ua_ok = 0;
   logic        va_unimpl = 0, pa_unimpl = 0, stop_follows = 1;

   logic        out_vld, ip_redirect, link_we, pfs_we, frame_we;
   logic [63:0] next_ip, link_data;
   logic [2:0]  link_sel;
   logic [37:0] pfs_frame;
   logic [5:0]  pfs_epi;
   logic [1:0]  pfs_pl;
   logic [6:0]  nf_size, nf_locals, nf_rbgr, nf_rbfr;
   logic [3:0]  nf_rot;
   logic [5:0]  nf_rbpr;
   logic        ill_op, undef_err, ua_trap, tb_trap, preserve_req;

   lbr_call_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .cur_ip(cur_ip), .disp(disp),
      .is_call(is_call), .pred(pred), .link_idx(link_idx),
      .cf_size(frin[6:0]), .cf_locals(frin[13:7]), .cf_rot(frin[17:14]),
      .cf_rbgr(frin[24:18]), .cf_rbfr(frin[31:25]), .cf_rbpr(frin[37:32]),
      .epi_cnt(epi_cnt), .cur_pl(cur_pl), .trans_on(trans_on), .tb_en(tb_en),
      .feat_ok(feat_ok), .early_ua_ok(early_ua_ok), .va_unimpl(va_unimpl),
      .pa_unimpl(pa_unimpl), .stop_follows(stop_follows),
      .out_vld(out_vld), .ip_redirect(ip_redirect), .next_ip(next_ip),
      .link_we(link_we), .link_sel(link_sel), .link_data(link_data),
      .pfs_we(pfs_we), .pfs_frame(pfs_frame), .pfs_epi(pfs_epi), .pfs_pl(pfs_pl),
      .frame_we(frame_we), .nf_size(nf_size), .nf_locals(nf_locals),
      .nf_rot(nf_rot), .nf_rbgr(nf_rbgr), .nf_rbfr(nf_rbfr), .nf_rbpr(nf_rbpr),
      .ill_op(ill_op), .undef_err(undef_err), .ua_trap(ua_trap),
      .tb_trap(tb_trap), .preserve_req(preserve_req)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   stim_t sbq[$];

   task automatic chk(input string tag, input string what,
                      input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic drive(input stim_t s);
      @(negedge clk);
      in_vld = 1; cur_ip = s.ip; disp = s.d; is_call = s.call; pred = s.pred;
      link_idx = s.li; frin = s.fr; epi_cnt = s.epi; cur_pl = s.pl;
      trans_on = s.tr; tb_en = s.tb; feat_ok = s.feat; early_ua_ok = s.early;
      va_unimpl = s.va; pa_unimpl = s.pa; stop_follows = s.stop;
      sbq.push_back(s);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_vld = 0;
      end
   endtask

   function automatic stim_t base();
      stim_t s;
      s.ip = 64'h0000_1234_5678_9AB0; s.d = 60'h0000_0000_0000_123;
      s.call = 0; s.pred = 1; s.li = 3'd5;
      s.fr = {6'h2A, 7'h11, 7'h22, 4'h3, 7'd10, 7'd40};
      s.epi = 6'h15; s.pl = 2'd3; s.tr = 1; s.tb = 0; s.feat = 1;
      s.early = 0; s.va = 0; s.pa = 0; s.stop = 1;
      return s;
   endfunction

   // monitor: compare each result against a model of the requirements
   always @(posedge clk) begin
      #2;
      if (rst_n && out_vld) begin
         if (sbq.size() == 0) begin
            chk("R1", "unexpected out_vld", 64'd1, 64'd0);
         end else begin
            stim_t s;
            logic ok, tk, ct;
            logic [37:0] exp_nf;
            s  = sbq.pop_front();
            ok = s.feat && s.stop;
            tk = ok && s.pred;
            ct = tk && s.call;
            exp_nf = ct ? {31'd0, 7'(s.fr[6:0] - s.fr[13:7])} : s.fr;
            chk("R2", "ip_redirect", 64'(ip_redirect), 64'(tk));
            if (tk) chk("R1", "next_ip target", next_ip, s.ip + {s.d, 4'h0});
            else    chk("R2", "next_ip fallthru", next_ip, s.ip + 64'd16);
            chk("R3", "link_we", 64'(link_we), 64'(ct));
            if (ct) begin
               chk("R3", "link_sel", 64'(link_sel), 64'(s.li));
               chk("R3", "link_data", link_data, s.ip + 64'd16);
               chk("R4", "pfs_frame", 64'(pfs_frame), 64'(s.fr));
               chk("R4", "pfs_epi", 64'(pfs_epi), 64'(s.epi));
               chk("R4", "pfs_pl", 64'(pfs_pl), 64'(s.pl));
            end
            chk("R4", "pfs_we", 64'(pfs_we), 64'(ct));
            chk("R5", "frame_we", 64'(frame_we), 64'(ct));
            chk("R5", "preserve_req", 64'(preserve_req), 64'(ct));
            chk(ct ? "R5" : "R6", "new frame",
                64'({nf_rbpr, nf_rbfr, nf_rbgr, nf_rot, nf_locals, nf_size}), 64'(exp_nf));
            chk("R7", "ill_op", 64'(ill_op), 64'(!s.feat));
            chk("R8", "undef_err", 64'(undef_err), 64'(s.feat && !s.stop));
            chk("R9", "ua_trap", 64'(ua_trap),
                64'(tk && !s.early && (s.tr ? s.va : s.pa)));
            chk("R10", "tb_trap", 64'(tb_trap), 64'(tk && s.tb));
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      stim_t s;
      repeat (3) @(posedge clk);
      #1;
      // R11 reset state
      chk("R11", "out_vld in reset", 64'(out_vld), 64'd0);
      chk("R11", "strobes in reset",
          64'({ip_redirect, link_we, pfs_we, frame_we, ill_op, undef_err,
               ua_trap, tb_trap, preserve_req}), 64'd0);
      @(negedge clk); rst_n = 1;
      idle(2);
      #1;
      chk("R11", "out_vld idle", 64'(out_vld), 64'd0);
      chk("R11", "strobes idle",
          64'({ip_redirect, link_we, pfs_we, frame_we, preserve_req, ua_trap, tb_trap}), 64'd0);

      // R2 conditional taken and not taken
      s = base(); drive(s);
      s.pred = 0; drive(s);
      // R3 R4 R5 taken call, then not-taken call (R6)
      s = base(); s.call = 1; drive(s);
      s.pred = 0; drive(s);
      idle(1);
      // R7 illegal operation with a would-be taken call
      s = base(); s.call = 1; s.feat = 0; s.tb = 1; s.va = 1; drive(s);
      // R7 illegal with missing stop: fault wins (R8)
      s.stop = 0; drive(s);
      // R8 missing stop
      s = base(); s.call = 1; s.stop = 0; s.tb = 1; drive(s);
      idle(1);
      // R9 virtual flag with translation on
      s = base(); s.va = 1; drive(s);
      // R9 physical flag ignored when translation on
      s = base(); s.pa = 1; drive(s);
      // R9 physical flag with translation off
      s = base(); s.tr = 0; s.pa = 1; drive(s);
      // R9 early faulting suppresses the trap
      s = base(); s.early = 1; s.va = 1; drive(s);
      // R9 no trap when not taken
      s = base(); s.pred = 0; s.va = 1; s.tb = 1; drive(s);
      // R10 taken-branch trap alone
      s = base(); s.tb = 1; drive(s);
      // R9 R10 both traps in one cycle on a taken call
      s = base(); s.call = 1; s.tb = 1; s.va = 1; s.li = 3'd2; drive(s);
      idle(1);
      // R1 wrap-around target, negative displacement
      s = base(); s.ip = 64'hFFFF_FFFF_FFFF_FFF0; s.d = 60'h000_0000_0000_0002; drive(s);
      s = base(); s.ip = 64'h0000_0000_0000_0100; s.d = 60'hFFF_FFFF_FFFF_FFFF; drive(s);
      // R5 call with zero locals and locals equal to size
      s = base(); s.call = 1; s.fr = {6'h3F, 7'h7F, 7'h7F, 4'hF, 7'd0, 7'd96};
      s.epi = 6'h3F; s.pl = 2'd0; s.li = 3'd7; drive(s);
      s.fr = {6'h01, 7'h02, 7'h03, 4'h4, 7'd33, 7'd33}; s.ip = 64'hFFFF_FFFF_FFFF_FFF0; drive(s);
      idle(3);
      #1;
      // R1 every request produced exactly one result
      chk("R1", "pending results", 64'(sbq.size()), 64'd0);
      chk("R11", "out_vld after drain", 64'(out_vld), 64'd0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule